// File: doc/BRIEF.md
# LCD Panel Timing Generator

This block produces the raster timing for a parallel RGB panel: horizontal sync, vertical sync, data-enable and an end-of-frame interrupt. A pixel counter and a line counter run inside programmed totals. Each sync pulse starts at count zero and ends at a programmed position. The active window lies at absolute programmed start and end positions inside the same total, so porches follow from where the window is placed and are not set as separate values.

Software programs the timing through a small register port, then sets the run bit. Timing values written while the raster runs are held back and take effect at the start of the next frame. Clearing the run bit lets the current frame finish; a status bit then reports that the raster has stopped. A special-panel mode adds per-line strobes and a reversal signal that toggles once per line.

Top module: `lcd_timing_gen`

## Requirements
- R1: The pixel counter runs from 0 to h_total-1. hsync is active for pixel counts below hsync_end, so a line lasts h_total clocks and the pulse lasts hsync_end clocks.
- R2: The line counter advances once per line and runs from 0 to v_total-1. vsync is active on lines below vsync_end, so a frame lasts h_total*v_total clocks.
- R3: Data-enable is active only while the pixel count lies in [h_start, h_end) and the line count lies in [v_start, v_end).
- R4: Config register bits 0, 1 and 2 make hsync, vsync and data-enable active-low. Bit 3 drives the pixel-edge select output high (data changes on the falling edge).
- R5: The end-of-frame flag (status bit 0) is set on the last pixel of every frame. Writing the status register with bit 0 at zero clears it, and a set on the same cycle wins. The interrupt output is the flag gated by control bit 1.
- R6: Clearing control bit 0 while running lets the current frame complete. At the frame boundary the counters return to zero, and every output goes to its inactive level. Status bit 1 (stopped) stays 0 until then.
- R7: With config bit 4 set, strobes A and B pulse for one pixel at pixel count h_end. Strobe S pulses for one pixel at pixel count hsync_end. The reversal output toggles at the last pixel of each line.
- R8: With config bit 4 clear, strobes A, B, S and the reversal output are held at 0.
- R9: Timing registers written while running do not change the raster until the next frame starts.
- R10: After reset the raster is stopped and status reads 2 (stopped set, flag clear). hsync, vsync and data-enable sit at their inactive levels.
- R11: The register map is as follows. Address 0 is control: bit 0 is run and bit 1 is interrupt enable. Address 1 is config: bits 4..0. Address 2 holds hsync_end in [15:0] and address 3 holds vsync_end in [15:0]. Address 4 holds h_start in [15:0] and h_end in [31:16]. Address 5 holds v_start and v_end in the same layout. Address 6 holds h_total in [15:0] and v_total in [31:16]. Address 7 is status. Reads return the register one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Registered read data |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data-enable |
| pclk_fall_o | output | 1 | Pixel-edge select |
| eof_irq_o | output | 1 | End-of-frame interrupt |
| sp_end_a_o | output | 1 | Special-panel strobe A |
| sp_end_b_o | output | 1 | Special-panel strobe B |
| sp_sync_o | output | 1 | Special-panel strobe S |
| sp_rev_o | output | 1 | Special-panel reversal |

## Verification
The assertions assume a sane programmed raster. That means h_total and v_total are at least 2 and fit the counter width, each sync end lies below its total, and each window start is no greater than its end, which is no greater than the total. The stimulus writes only such values, including the wider line length used for the deferred-update case. All measurements are periods, pulse counts over a whole frame, or offsets from the vsync rise. They therefore stay valid whatever the fixed output latency.

// File: rtl/lcd_tg_pkg.sv
package lcd_tg_pkg;
  localparam int TW = 16;

  localparam logic [2:0] A_CTRL   = 3'd0;
  localparam logic [2:0] A_CFG    = 3'd1;
  localparam logic [2:0] A_HSE    = 3'd2;
  localparam logic [2:0] A_VSE    = 3'd3;
  localparam logic [2:0] A_HWIN   = 3'd4;
  localparam logic [2:0] A_VWIN   = 3'd5;
  localparam logic [2:0] A_TOTAL  = 3'd6;
  localparam logic [2:0] A_STATUS = 3'd7;

  typedef struct packed {
    logic [TW-1:0] hs_end;
    logic [TW-1:0] vs_end;
    logic [TW-1:0] ha_start;
    logic [TW-1:0] ha_end;
    logic [TW-1:0] va_start;
    logic [TW-1:0] va_end;
    logic [TW-1:0] h_total;
    logic [TW-1:0] v_total;
  } timing_t;

  typedef struct packed {
    logic special;
    logic pclk_fall;
    logic de_low;
    logic vs_low;
    logic hs_low;
  } cfg_t;
endpackage

// File: rtl/lcd_tg_regs.sv
module lcd_tg_regs
  import lcd_tg_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  input  logic          frame_end,
  input  logic          stopped,
  output logic [DW-1:0] rd_data,
  output timing_t       live,
  output cfg_t          cfg,
  output logic          run_req,
  output logic          irq_en,
  output logic          eof_flag
);
  localparam int HI = 2 * TW;

  always_ff @(posedge clk) begin
    if (rst) begin
      live     <= '0;
      cfg      <= '0;
      run_req  <= 1'b0;
      irq_en   <= 1'b0;
      eof_flag <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          A_CTRL:  begin run_req <= wr_data[0]; irq_en <= wr_data[1]; end
          A_CFG:   cfg <= cfg_t'(wr_data[4:0]);
          A_HSE:   live.hs_end <= wr_data[TW-1:0];
          A_VSE:   live.vs_end <= wr_data[TW-1:0];
          A_HWIN:  begin live.ha_start <= wr_data[TW-1:0]; live.ha_end <= wr_data[HI-1:TW]; end
          A_VWIN:  begin live.va_start <= wr_data[TW-1:0]; live.va_end <= wr_data[HI-1:TW]; end
          A_TOTAL: begin live.h_total <= wr_data[TW-1:0]; live.v_total <= wr_data[HI-1:TW]; end
          default: ;
        endcase
      end
      if (frame_end)
        eof_flag <= 1'b1;
      else if (wr_en && wr_addr == A_STATUS && !wr_data[0])
        eof_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else begin
      case (rd_addr)
        A_CTRL:   rd_data <= DW'({irq_en, run_req});
        A_CFG:    rd_data <= DW'(cfg);
        A_HSE:    rd_data <= DW'(live.hs_end);
        A_VSE:    rd_data <= DW'(live.vs_end);
        A_HWIN:   rd_data <= DW'({live.ha_end, live.ha_start});
        A_VWIN:   rd_data <= DW'({live.va_end, live.va_start});
        A_TOTAL:  rd_data <= DW'({live.v_total, live.h_total});
        default:  rd_data <= DW'({stopped, eof_flag});
      endcase
    end
  end

  // R5: a frame end always leaves the flag set
  a_r5_flag_sets: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> eof_flag);
  // R5: a clearing write with no coincident frame end clears the flag
  a_r5_flag_clears: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == A_STATUS && !wr_data[0] && !frame_end) |=> !eof_flag);
endmodule

// File: rtl/lcd_tg_counter.sv
module lcd_tg_counter
  import lcd_tg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run_req,
  input  timing_t       live,
  output logic          run,
  output logic [CW-1:0] h,
  output logic [CW-1:0] v,
  output timing_t       act,
  output logic          frame_end
);
  logic line_end;

  assign line_end  = TW'(h) == act.h_total - 1'b1;
  assign frame_end = run && line_end && (TW'(v) == act.v_total - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      h   <= '0;
      v   <= '0;
      act <= '0;
    end else if (!run) begin
      h <= '0;
      v <= '0;
      if (run_req) begin
        run <= 1'b1;
        act <= live;
      end
    end else if (frame_end) begin
      h <= '0;
      v <= '0;
      if (!run_req) run <= 1'b0;
      else          act <= live;
    end else if (line_end) begin
      h <= '0;
      v <= v + 1'b1;
    end else begin
      h <= h + 1'b1;
    end
  end

  // R1: pixel count never reaches the line total while running
  a_r1_h_in_line: assert property (@(posedge clk) disable iff (rst)
    run |-> TW'(h) < act.h_total);
  // R6: a stopped raster keeps both counters at zero
  a_r6_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !run |-> (h == '0 && v == '0));
  // R9: active timing changes only across a frame boundary
  a_r9_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    (run && !frame_end) |=> $stable(act));
endmodule

// File: rtl/lcd_tg_outputs.sv
module lcd_tg_outputs
  import lcd_tg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [CW-1:0] h,
  input  logic [CW-1:0] v,
  input  timing_t       act,
  input  cfg_t          cfg,
  input  logic          irq_en,
  input  logic          eof_flag,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          pclk_fall_o,
  output logic          eof_irq_o,
  output logic          sp_end_a_o,
  output logic          sp_end_b_o,
  output logic          sp_sync_o,
  output logic          sp_rev_o
);
  localparam int NSIG = 3;

  logic [TW-1:0]   hx, vx;
  logic [NSIG-1:0] raw, pol, drv;
  logic            sp_on, at_line_end;

  assign hx     = TW'(h);
  assign vx     = TW'(v);
  assign raw[0] = run && (hx < act.hs_end);
  assign raw[1] = run && (vx < act.vs_end);
  assign raw[2] = run && (hx >= act.ha_start) && (hx < act.ha_end)
                      && (vx >= act.va_start) && (vx < act.va_end);
  assign pol    = {cfg.de_low, cfg.vs_low, cfg.hs_low};
  assign sp_on  = run && cfg.special;
  assign at_line_end = hx == act.h_total - 1'b1;

  for (genvar i = 0; i < NSIG; i++) begin : g_pol
    always_ff @(posedge clk) begin
      if (rst) drv[i] <= 1'b0;
      else     drv[i] <= raw[i] ^ pol[i];
    end
  end

  assign hsync_o = drv[0];
  assign vsync_o = drv[1];
  assign de_o    = drv[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      pclk_fall_o <= 1'b0;
      eof_irq_o   <= 1'b0;
      sp_end_a_o  <= 1'b0;
      sp_end_b_o  <= 1'b0;
      sp_sync_o   <= 1'b0;
      sp_rev_o    <= 1'b0;
    end else begin
      pclk_fall_o <= cfg.pclk_fall;
      eof_irq_o   <= eof_flag && irq_en;
      sp_end_a_o  <= sp_on && (hx == act.ha_end);
      sp_end_b_o  <= sp_on && (hx == act.ha_end);
      sp_sync_o   <= sp_on && (hx == act.hs_end);
      if (!sp_on)           sp_rev_o <= 1'b0;
      else if (at_line_end) sp_rev_o <= !sp_rev_o;
    end
  end

  // R8: special strobes stay low while the mode is off
  a_r8_strobes_idle: assert property (@(posedge clk) disable iff (rst)
    !cfg.special |=> !(sp_end_a_o || sp_end_b_o || sp_sync_o || sp_rev_o));
  // R6: a stopped raster drives data-enable to its inactive level
  a_r6_de_idle: assert property (@(posedge clk) disable iff (rst)
    !run |=> de_o == $past(cfg.de_low));
  // R3: data-enable never active outside the vertical window
  a_r3_de_vwin: assert property (@(posedge clk) disable iff (rst)
    (vx >= act.va_end) |=> de_o == $past(cfg.de_low));
endmodule

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen
  import lcd_tg_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 32,
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic          pclk_fall_o,
  output logic          eof_irq_o,
  output logic          sp_end_a_o,
  output logic          sp_end_b_o,
  output logic          sp_sync_o,
  output logic          sp_rev_o
);
  timing_t       live, act;
  cfg_t          cfg;
  logic          run_req, irq_en, eof_flag, run, frame_end;
  logic [CW-1:0] h, v;

  lcd_tg_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .frame_end(frame_end), .stopped(!run), .rd_data(rd_data),
    .live(live), .cfg(cfg), .run_req(run_req), .irq_en(irq_en), .eof_flag(eof_flag)
  );

  lcd_tg_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .run_req(run_req), .live(live), .run(run),
    .h(h), .v(v), .act(act), .frame_end(frame_end)
  );

  lcd_tg_outputs #(.CW(CW)) u_out (
    .clk(clk), .rst(rst), .run(run), .h(h), .v(v), .act(act), .cfg(cfg),
    .irq_en(irq_en), .eof_flag(eof_flag), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .de_o(de_o), .pclk_fall_o(pclk_fall_o), .eof_irq_o(eof_irq_o),
    .sp_end_a_o(sp_end_a_o), .sp_end_b_o(sp_end_b_o), .sp_sync_o(sp_sync_o),
    .sp_rev_o(sp_rev_o)
  );

  // R6: the raster stops only at a frame boundary
  a_r6_stop_at_boundary: assert property (@(posedge clk) disable iff (rst)
    (run && !frame_end) |=> run);
endmodule

// File: tb/tb_lcd_timing_gen.sv
module tb_lcd_timing_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic hsync_o, vsync_o, de_o, pclk_fall_o, eof_irq_o;
  logic sp_end_a_o, sp_end_b_o, sp_sync_o, sp_rev_o;
  logic [8:0] obs;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  localparam int HS = 0, VS = 1, DE = 2, IRQ = 3, PF = 4, SA = 5, SB = 6, SS = 7, RV = 8;
  localparam int FRAME = 160;

  always #10 clk = ~clk;

  lcd_timing_gen dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .hsync_o(hsync_o), .vsync_o(vsync_o),
    .de_o(de_o), .pclk_fall_o(pclk_fall_o), .eof_irq_o(eof_irq_o),
    .sp_end_a_o(sp_end_a_o), .sp_end_b_o(sp_end_b_o), .sp_sync_o(sp_sync_o),
    .sp_rev_o(sp_rev_o)
  );

  assign obs = {sp_rev_o, sp_sync_o, sp_end_b_o, sp_end_a_o, pclk_fall_o,
                eof_irq_o, de_o, vsync_o, hsync_o};

  task automatic check(input string req, input int got, input int exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = int'(rd_data);
  endtask

  task automatic wait_rise(input int idx);
    logic prev;
    prev = obs[idx];
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (!prev && obs[idx]) return;
      prev = obs[idx];
    end
    check("wait timeout", 0, 1);
  endtask

  task automatic count_high(input int idx, input int len, output int n);
    n = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (obs[idx]) n++;
    end
  endtask

  task automatic count_toggles(input int idx, input int len, output int n);
    logic prev;
    n = 0;
    prev = obs[idx];
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (obs[idx] != prev) n++;
      prev = obs[idx];
    end
  endtask

  task automatic gap(input int a, input int b, output int n);
    logic prev;
    wait_rise(a);
    prev = obs[b];
    n = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      n++;
      if (!prev && obs[b]) return;
      prev = obs[b];
    end
  endtask

  task automatic program_raster(input int htot);
    wr(3'd2, 32'd3);
    wr(3'd3, 32'd2);
    wr(3'd4, {16'd16, 16'd6});
    wr(3'd5, {16'd7, 16'd3});
    wr(3'd6, {16'd8, 16'(htot)});
  endtask

  task automatic t_reset;
    int d, n;
    rd(3'd7, d);          check("R10 status after reset", d, 2);
    count_high(HS, 50, n); check("R10 hsync idle", n, 0);
    count_high(DE, 50, n); check("R10 de idle", n, 0);
  endtask

  task automatic t_regmap;
    int d;
    program_raster(20);
    rd(3'd4, d); check("R11 h window readback", d, 32'h0010_0006);
    rd(3'd6, d); check("R11 totals readback", d, 32'h0008_0014);
    wr(3'd0, 32'd1);
  endtask

  task automatic t_hsync;
    int n;
    gap(HS, HS, n);               check("R1 line period", n, 20);
    count_high(HS, FRAME, n);     check("R1 hsync clocks per frame", n, 24);
  endtask

  task automatic t_vsync;
    int n;
    gap(VS, VS, n);               check("R2 frame period", n, FRAME);
    count_high(VS, FRAME, n);     check("R2 vsync clocks per frame", n, 40);
  endtask

  task automatic t_de;
    int n;
    count_high(DE, FRAME, n);     check("R3 de clocks per frame", n, 40);
    gap(VS, DE, n);               check("R3 de first pixel offset", n, 66);
  endtask

  task automatic t_polarity;
    int n;
    wr(3'd1, 32'h0F);
    count_high(HS, FRAME, n);     check("R4 hsync active-low", n, 136);
    count_high(VS, FRAME, n);     check("R4 vsync active-low", n, 120);
    count_high(DE, FRAME, n);     check("R4 de active-low", n, 120);
    check("R4 pixel edge select", int'(obs[PF]), 1);
    wr(3'd1, 32'h00);
    @(negedge clk);
    check("R4 pixel edge select off", int'(obs[PF]), 0);
  endtask

  task automatic t_special;
    int n;
    count_high(SA, FRAME, n);     check("R8 strobe A off", n, 0);
    count_high(SS, FRAME, n);     check("R8 strobe S off", n, 0);
    count_toggles(RV, FRAME, n);  check("R8 reversal off", n, 0);
    wr(3'd1, 32'h10);
    count_high(SA, FRAME, n);     check("R7 strobe A per frame", n, 8);
    count_high(SB, FRAME, n);     check("R7 strobe B per frame", n, 8);
    count_high(SS, FRAME, n);     check("R7 strobe S per frame", n, 8);
    count_toggles(RV, FRAME, n);  check("R7 reversal toggles", n, 8);
    gap(VS, SS, n);               check("R7 strobe S position", n, 3);
    gap(VS, SA, n);               check("R7 strobe A position", n, 16);
    wr(3'd1, 32'h00);
  endtask

  task automatic t_eof;
    int d, n;
    wr(3'd7, 32'd0);
    wr(3'd0, 32'd3);
    wait_rise(IRQ);
    rd(3'd7, d);                  check("R5 flag set at frame end", d & 1, 1);
    wr(3'd7, 32'd0);
    @(negedge clk);               check("R5 irq cleared", int'(obs[IRQ]), 0);
    wr(3'd0, 32'd1);
    count_high(IRQ, 2 * FRAME, n); check("R5 irq masked", n, 0);
    rd(3'd7, d);                  check("R5 flag set while masked", d & 1, 1);
  endtask

  task automatic t_shadow;
    int n;
    wait_rise(VS);
    repeat (30) @(negedge clk);
    wr(3'd6, {16'd8, 16'd24});
    gap(HS, HS, n);               check("R9 old line length kept", n, 20);
    wait_rise(VS);
    gap(HS, HS, n);               check("R9 new line length next frame", n, 24);
    wr(3'd6, {16'd8, 16'd20});
    wait_rise(VS);
    wait_rise(VS);
  endtask

  task automatic t_disable;
    int d, n;
    wait_rise(VS);
    repeat (10) @(negedge clk);
    wr(3'd0, 32'd0);
    rd(3'd7, d);                  check("R6 still running after request", (d >> 1) & 1, 0);
    count_high(HS, 40, n);        check("R6 frame continues", int'(n > 0), 1);
    repeat (300) @(negedge clk);
    rd(3'd7, d);                  check("R6 stopped status", (d >> 1) & 1, 1);
    count_high(HS, 100, n);       check("R6 hsync inactive", n, 0);
    count_high(VS, 100, n);       check("R6 vsync inactive", n, 0);
    count_high(DE, 100, n);       check("R6 de inactive", n, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_regmap;
    t_hsync;
    t_vsync;
    t_de;
    t_polarity;
    t_special;
    t_eof;
    t_shadow;
    t_disable;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule